// File: doc/BRIEF.md
# 8b/10b Transmit Encoder with Start-up Commas and Disparity Override

This block sits on the transmit side of a serial link. Each clock it takes one byte and a flag that marks the byte as a control character. It returns one registered 10-bit code group built from the usual 5b/6b and 3b/4b sub-block codes. It keeps the running disparity from group to group and shows the disparity after the group just sent, so the link stays DC-balanced. When the control flag is set, the byte must name one of the twelve defined special characters. Any other byte raises an error flag and is sent as a data character.

Two features frame the encoder. While reset is held, the output is a steady comma (K28.5) taken from the negative-disparity column. Once reset releases, the block sends a fixed number of comma groups (three by default) so that the far end can lock on. Only then does it accept user bytes. A per-cycle override lets the user pick the disparity column for the current group, and the tracking carries on from that choice. Code group bit 0 is the first bit on the line.

Top module: `tx8b10b_encoder`

## Requirements
- R1: While `rst_n` is low, the byte, control and override inputs have no effect. At each clock `code_out` is 0x17C, `rd_pos` is 0 and `ctrl_err` is 0.
- R2: On the first three clocks after `rst_n` rises, `code_out` shows K28.5 as 0x17C, then 0x283, then 0x17C, with `rd_pos` at 1, 0, 1. The byte, control and override inputs are ignored on those clocks and `ctrl_err` stays 0.
- R3: The first user byte is the one sampled on the fourth clock after reset release. It is encoded starting from positive disparity. Each later byte appears on `code_out` one clock after it is sampled.
- R4: A data byte with bits HGF EDCBA has x = byte[4:0] and y = byte[7:5]. It maps to the standard 5b/6b code abcdei and 3b/4b code fghj, placed as code_out[0]=a up to code_out[5]=i and code_out[6]=f up to code_out[9]=j. For D.x.7 the alternate 4b form is used when x is 17, 18 or 20 at negative disparity, and when x is 11, 13 or 14 at positive disparity.
- R5: `rd_pos` (1 = positive) flips after each sub-block whose ones and zeros are unequal. Every group holds 4, 5 or 6 ones: 6 ones leave `rd_pos` at 1 and 4 ones leave it at 0.
- R6: With `ctrl_en` high, the accepted characters are K28.0 to K28.7 (byte[4:0] = 28), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE). K28.5 (0xBC) encodes as 0x17C at negative and 0x283 at positive disparity.
- R7: When `ctrl_en` is high with any other byte, `ctrl_err` is 1 on the same cycle as the group, and the group is the data encoding of that byte.
- R8: When `force_disp` is high outside the start-up commas, the group uses the positive column if `disp_sel` is 0 and the negative column if it is 1. Tracking continues from that choice.
- R9: A run of K28.5 groups with no override alternates between 0x17C and 0x283.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_in | input | 8 | Byte to encode |
| ctrl_en | input | 1 | Marks `data_in` as a special character |
| force_disp | input | 1 | Override the disparity for this group |
| disp_sel | input | 1 | Forced column: 0 positive, 1 negative |
| code_out | output | 10 | Registered code group, bit 0 first on the line |
| rd_pos | output | 1 | Running disparity after `code_out` (1 = positive) |
| ctrl_err | output | 1 | Invalid special character was requested |

## Verification
The embedded properties hold on every cycle. They cover the ones count of each group and its agreement with the reported disparity, the comma-only output during the start-up window, the comma alternation, the error flag for a bad control byte, and the first sub-block's weight under a forced column. Only the directed scenarios can show that each of the 256 bytes and 12 special characters, at both disparities, gives exactly the right code group. The same holds for the exact start-up order and its one-clock latency, and for tracking carrying on from a forced choice.

// File: rtl/tx8b10b_pkg.sv
// Shared constants and helpers for the 8b/10b transmit encoder.
// Assumes code groups are 10 bits and input symbols are 8 bits.
package tx8b10b_pkg;
    localparam int SYM_W  = 8;
    localparam int CODE_W = 10;
    localparam int LO_W   = 6;
    localparam int HI_W   = 4;
    localparam logic [SYM_W-1:0]  COMMA_SYM = 8'hBC;
    localparam logic [CODE_W-1:0] COMMA_NEG = 10'h17C;

    // Number of ones in a 6-bit sub-block.
    function automatic int ones6(input logic [LO_W-1:0] v);
        int n = 0;
        for (int i = 0; i < LO_W; i++) n += int'(v[i]);
        return n;
    endfunction

    // Number of ones in a 4-bit sub-block.
    function automatic int ones4(input logic [HI_W-1:0] v);
        int n = 0;
        for (int i = 0; i < HI_W; i++) n += int'(v[i]);
        return n;
    endfunction

    // True when the byte names one of the twelve defined special characters.
    function automatic logic special_ok(input logic [SYM_W-1:0] s);
        return (s[4:0] == 5'd28) || (s == 8'hF7) || (s == 8'hFB) ||
               (s == 8'hFD) || (s == 8'hFE);
    endfunction
endpackage

// File: rtl/tx_sync_seq.sv
// Start-up sequencer: counts the comma groups sent after reset release.
// Assumes a synchronous active-low reset; holds sync_active high for
// exactly SYNC_GROUPS clocks after rst_n rises.
module tx_sync_seq #(
    parameter int SYNC_GROUPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic sync_active
);
    localparam int CW = (SYNC_GROUPS < 1) ? 1 : $clog2(SYNC_GROUPS + 1);
    localparam logic [CW-1:0] LAST = CW'(SYNC_GROUPS);

    logic [CW-1:0] sent_cnt;

    assign sync_active = (sent_cnt != LAST);

    // Count start-up groups until the programmed number has been sent.
    always_ff @(posedge clk) begin
        if (!rst_n)           sent_cnt <= '0;
        else if (sync_active) sent_cnt <= sent_cnt + CW'(1);
    end
endmodule

// File: rtl/tx_sub6_enc.sv
// 5b/6b sub-block encoder. Gives abcdei (a in bit 5) for the given
// running disparity and the disparity after the sub-block.
// Assumes k28_sel is set only for the K28 special column.
module tx_sub6_enc
    import tx8b10b_pkg::*;
(
    input  logic [4:0]      x_in,
    input  logic            k28_sel,
    input  logic            rd_pos_in,
    output logic [LO_W-1:0] abcdei,
    output logic            rd_pos_out
);
    logic [LO_W-1:0] neg_form;
    logic            unbal;

    // Negative-disparity column of the 5b/6b table.
    always_comb begin
        case (x_in)
            5'd0:  neg_form = 6'b100111;
            5'd1:  neg_form = 6'b011101;
            5'd2:  neg_form = 6'b101101;
            5'd3:  neg_form = 6'b110001;
            5'd4:  neg_form = 6'b110101;
            5'd5:  neg_form = 6'b101001;
            5'd6:  neg_form = 6'b011001;
            5'd7:  neg_form = 6'b111000;
            5'd8:  neg_form = 6'b111001;
            5'd9:  neg_form = 6'b100101;
            5'd10: neg_form = 6'b010101;
            5'd11: neg_form = 6'b110100;
            5'd12: neg_form = 6'b001101;
            5'd13: neg_form = 6'b101100;
            5'd14: neg_form = 6'b011100;
            5'd15: neg_form = 6'b010111;
            5'd16: neg_form = 6'b011011;
            5'd17: neg_form = 6'b100011;
            5'd18: neg_form = 6'b010011;
            5'd19: neg_form = 6'b110010;
            5'd20: neg_form = 6'b001011;
            5'd21: neg_form = 6'b101010;
            5'd22: neg_form = 6'b011010;
            5'd23: neg_form = 6'b111010;
            5'd24: neg_form = 6'b110011;
            5'd25: neg_form = 6'b100110;
            5'd26: neg_form = 6'b010110;
            5'd27: neg_form = 6'b110110;
            5'd28: neg_form = k28_sel ? 6'b001111 : 6'b001110;
            5'd29: neg_form = 6'b101110;
            5'd30: neg_form = 6'b011110;
            default: neg_form = 6'b101011;
        endcase
    end

    // Pick the column and update the disparity.
    always_comb begin
        unbal      = (ones6(neg_form) != 3);
        abcdei     = (rd_pos_in && (unbal || neg_form == 6'b111000)) ? ~neg_form : neg_form;
        rd_pos_out = rd_pos_in ^ unbal;
    end
endmodule

// File: rtl/tx_sub4_enc.sv
// 3b/4b sub-block encoder with the D.x.7 alternate selection. Gives fghj
// (f in bit 3) and the disparity after the sub-block.
// Assumes rd_pos_in is the disparity after the 6b sub-block.
module tx_sub4_enc
    import tx8b10b_pkg::*;
(
    input  logic [4:0]      x_in,
    input  logic [2:0]      y_in,
    input  logic            k_sel,
    input  logic            rd_pos_in,
    output logic [HI_W-1:0] fghj,
    output logic            rd_pos_out
);
    logic [HI_W-1:0] neg_form;
    logic            use_alt;
    logic            invert;

    // Decide whether D.x.7 takes its alternate form.
    always_comb begin
        use_alt = 1'b0;
        if (!k_sel && y_in == 3'd7) begin
            if (!rd_pos_in) use_alt = (x_in == 5'd17) || (x_in == 5'd18) || (x_in == 5'd20);
            else            use_alt = (x_in == 5'd11) || (x_in == 5'd13) || (x_in == 5'd14);
        end
    end

    // Negative-disparity column for data and special characters.
    always_comb begin
        if (k_sel) begin
            case (y_in)
                3'd0: neg_form = 4'b1011;
                3'd1: neg_form = 4'b0110;
                3'd2: neg_form = 4'b1010;
                3'd3: neg_form = 4'b1100;
                3'd4: neg_form = 4'b1101;
                3'd5: neg_form = 4'b0101;
                3'd6: neg_form = 4'b1001;
                default: neg_form = 4'b0111;
            endcase
        end else begin
            case (y_in)
                3'd0: neg_form = 4'b1011;
                3'd1: neg_form = 4'b1001;
                3'd2: neg_form = 4'b0101;
                3'd3: neg_form = 4'b1100;
                3'd4: neg_form = 4'b1101;
                3'd5: neg_form = 4'b1010;
                3'd6: neg_form = 4'b0110;
                default: neg_form = use_alt ? 4'b0111 : 4'b1110;
            endcase
        end
    end

    // Pick the column and update the disparity.
    always_comb begin
        invert     = rd_pos_in && (k_sel || ones4(neg_form) != 2 || neg_form == 4'b1100);
        fghj       = invert ? ~neg_form : neg_form;
        rd_pos_out = rd_pos_in ^ (ones4(neg_form) != 2);
    end
endmodule

// File: rtl/tx8b10b_encoder.sv
// 8b/10b transmit encoder. Sends negative-column K28.5 while in reset and
// SYNC_GROUPS comma groups after release, then encodes user bytes with one
// clock of latency. It tracks running disparity and accepts a per-cycle
// forced column. Assumes a synchronous active-low reset.
module tx8b10b_encoder
    import tx8b10b_pkg::*;
#(
    parameter int SYNC_GROUPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SYM_W-1:0]  data_in,
    input  logic              ctrl_en,
    input  logic              force_disp,
    input  logic              disp_sel,
    output logic [CODE_W-1:0] code_out,
    output logic              rd_pos,
    output logic              ctrl_err
);
    logic              sync_active;
    logic [SYM_W-1:0]  sel_sym;
    logic              sel_k;
    logic              start_rd;
    logic              bad_ctrl;
    logic [LO_W-1:0]   lo_code;
    logic [HI_W-1:0]   hi_code;
    logic              mid_rd;
    logic              end_rd;
    logic [CODE_W-1:0] next_code;
    logic [CODE_W-1:0] code_q;
    logic              rd_q;
    logic              err_q;

    tx_sync_seq #(.SYNC_GROUPS(SYNC_GROUPS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_active (sync_active)
    );

    // Choose the symbol, character class and start disparity for this group.
    always_comb begin
        bad_ctrl = 1'b0;
        if (sync_active) begin
            sel_sym  = COMMA_SYM;
            sel_k    = 1'b1;
            start_rd = rd_q;
        end else begin
            sel_sym  = data_in;
            sel_k    = ctrl_en && special_ok(data_in);
            bad_ctrl = ctrl_en && !special_ok(data_in);
            start_rd = force_disp ? ~disp_sel : rd_q;
        end
    end

    tx_sub6_enc u_lo (
        .x_in       (sel_sym[4:0]),
        .k28_sel    (sel_k && sel_sym[4:0] == 5'd28),
        .rd_pos_in  (start_rd),
        .abcdei     (lo_code),
        .rd_pos_out (mid_rd)
    );

    tx_sub4_enc u_hi (
        .x_in       (sel_sym[4:0]),
        .y_in       (sel_sym[7:5]),
        .k_sel      (sel_k),
        .rd_pos_in  (mid_rd),
        .fghj       (hi_code),
        .rd_pos_out (end_rd)
    );

    // Place sub-block bits so that 'a' is sent first.
    for (genvar i = 0; i < LO_W; i++) begin : g_lo_bits
        assign next_code[i] = lo_code[LO_W-1-i];
    end
    for (genvar j = 0; j < HI_W; j++) begin : g_hi_bits
        assign next_code[LO_W+j] = hi_code[HI_W-1-j];
    end

    // Register the group, its end disparity and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= COMMA_NEG;
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            code_q <= next_code;
            rd_q   <= end_rd;
            err_q  <= bad_ctrl;
        end
    end

    assign code_out = code_q;
    assign rd_pos   = rd_q;
    assign ctrl_err = err_q;

    // Every group is near-balanced, and its weight agrees with the reported disparity.
    assert_group_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(code_out) >= 4 && $countones(code_out) <= 6));
    assert_weight_vs_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($countones(code_out) != 6 || rd_pos) && ($countones(code_out) != 4 || !rd_pos)));

    // Start-up window only sends commas and never flags an error.
    assert_sync_comma_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_active |=> ((code_out == 10'h17C || code_out == 10'h283) && !ctrl_err));

    // Comma from negative disparity is the 0x17C form.
    assert_comma_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_active && !force_disp && ctrl_en && data_in == 8'hBC && !rd_pos) |=> (code_out == 10'h17C));

    // An undefined special character raises the error flag.
    assert_bad_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_active && ctrl_en && !special_ok(data_in)) |=> ctrl_err);

    // A forced column sets the weight of the first sub-block.
    assert_force_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_active && force_disp && !disp_sel) |=> ($countones(code_out[5:0]) <= 3));
    assert_force_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_active && force_disp && disp_sel) |=> ($countones(code_out[5:0]) >= 3));
endmodule

// File: tb/tx8b10b_encoder_test.sv
module tx8b10b_encoder_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       ctrl_en = 1'b0;
    logic       force_disp = 1'b0;
    logic       disp_sel = 1'b0;
    logic [9:0] code_out;
    logic       rd_pos;
    logic       ctrl_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tx8b10b_encoder uut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .ctrl_en(ctrl_en),
        .force_disp(force_disp), .disp_sel(disp_sel),
        .code_out(code_out), .rd_pos(rd_pos), .ctrl_err(ctrl_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference code tables (negative column, a/f in the MSB).
    function automatic logic [5:0] ref6(input logic [4:0] x);
        logic [5:0] t [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001,
                               6'b110101, 6'b101001, 6'b011001, 6'b111000,
                               6'b111001, 6'b100101, 6'b010101, 6'b110100,
                               6'b001101, 6'b101100, 6'b011100, 6'b010111,
                               6'b011011, 6'b100011, 6'b010011, 6'b110010,
                               6'b001011, 6'b101010, 6'b011010, 6'b111010,
                               6'b110011, 6'b100110, 6'b010110, 6'b110110,
                               6'b001110, 6'b101110, 6'b011110, 6'b101011};
        return t[x];
    endfunction

    // Returns {rd_after, code}; rdp is the start disparity (1 = positive).
    function automatic logic [10:0] ref_enc(input logic [7:0] b, input logic k, input logic rdp);
        logic [3:0] dt [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
        logic [3:0] kt [8] = '{4'b1011, 4'b0110, 4'b1010, 4'b1100, 4'b1101, 4'b0101, 4'b1001, 4'b0111};
        logic [4:0] x = b[4:0];
        logic [2:0] y = b[7:5];
        logic [5:0] s6;
        logic [3:0] s4;
        logic [9:0] o;
        logic r = rdp;
        int n6, n4;
        s6 = (k && x == 5'd28) ? 6'b001111 : ref6(x);
        n6 = $countones(s6);
        if (r && (n6 != 3 || s6 == 6'b111000)) s6 = ~s6;
        if (n6 != 3) r = ~r;
        if (k) s4 = kt[y];
        else if (y == 3'd7 && ((!r && (x == 17 || x == 18 || x == 20)) ||
                               (r && (x == 11 || x == 13 || x == 14)))) s4 = 4'b0111;
        else s4 = dt[y];
        n4 = $countones(s4);
        if (r && (k || n4 != 2 || s4 == 4'b1100)) s4 = ~s4;
        if (n4 != 2) r = ~r;
        for (int i = 0; i < 6; i++) o[i] = s6[5-i];
        for (int i = 0; i < 4; i++) o[6+i] = s4[3-i];
        return {r, o};
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample after the clock edge.
    task automatic step(input logic [7:0] b, input logic k, input logic f, input logic v);
        data_in = b; ctrl_en = k; force_disp = f; disp_sel = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(8'h5A ^ 8'(i), 1'b1, 1'b1, 1'(i));
            check("R1 reset", {rd_pos, code_out}, {1'b0, 10'h17C});
            check("R1 reset err", {10'd0, ctrl_err}, 11'd0);
        end
    endtask

    task automatic t_sync();
        @(negedge clk);
        rst_n = 1'b1;
        step(8'h00, 1'b1, 1'b1, 1'b0);
        check("R2 sync1", {rd_pos, code_out}, {1'b1, 10'h17C});
        check("R2 sync1 err", {10'd0, ctrl_err}, 11'd0);
        step(8'h00, 1'b1, 1'b1, 1'b1);
        check("R2 sync2", {rd_pos, code_out}, {1'b0, 10'h283});
        step(8'h00, 1'b1, 1'b1, 1'b0);
        check("R2 sync3", {rd_pos, code_out}, {1'b1, 10'h17C});
        check("R2 sync3 err", {10'd0, ctrl_err}, 11'd0);
    endtask

    task automatic t_first_data();
        logic [10:0] e;
        e = ref_enc(8'h03, 1'b0, 1'b1);
        step(8'h03, 1'b0, 1'b0, 1'b0);
        check("R3 first byte", {rd_pos, code_out}, e);
        e = ref_enc(8'hF1, 1'b0, e[10]);
        step(8'hF1, 1'b0, 1'b0, 1'b0);
        check("R3 next byte", {rd_pos, code_out}, e);
    endtask

    task automatic t_force_continue();
        logic [10:0] e;
        e = ref_enc(8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b0, 1'b1, 1'b1);
        check("R8 forced negative", {rd_pos, code_out}, e);
        e = ref_enc(8'h00, 1'b0, e[10]);
        step(8'h00, 1'b0, 1'b0, 1'b0);
        check("R8 continue", {rd_pos, code_out}, e);
        e = ref_enc(8'hB5, 1'b0, 1'b1);
        step(8'hB5, 1'b0, 1'b1, 1'b0);
        check("R8 forced positive", {rd_pos, code_out}, e);
    endtask

    task automatic t_comma_run();
        step(8'hBC, 1'b1, 1'b1, 1'b1);
        check("R6 K28.5 neg", {rd_pos, code_out}, {1'b1, 10'h17C});
        for (int i = 0; i < 6; i++) begin
            step(8'hBC, 1'b1, 1'b0, 1'b0);
            check("R9 comma run", {rd_pos, code_out},
                  (i % 2 == 0) ? {1'b0, 10'h283} : {1'b1, 10'h17C});
        end
    endtask

    task automatic t_all_data();
        for (int v = 0; v < 2; v++) begin
            for (int b = 0; b < 256; b++) begin
                step(8'(b), 1'b0, 1'b1, 1'(v));
                check("R4 data table", {rd_pos, code_out}, ref_enc(8'(b), 1'b0, ~1'(v)));
                check("R5 data err", {10'd0, ctrl_err}, 11'd0);
            end
        end
    endtask

    task automatic t_kcodes();
        logic [7:0] ks [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
        for (int v = 0; v < 2; v++) begin
            foreach (ks[i]) begin
                step(ks[i], 1'b1, 1'b1, 1'(v));
                check("R6 special", {rd_pos, code_out}, ref_enc(ks[i], 1'b1, ~1'(v)));
                check("R6 special err", {10'd0, ctrl_err}, 11'd0);
            end
        end
        step(8'hBC, 1'b1, 1'b1, 1'b0);
        check("R6 K28.5 pos", {rd_pos, code_out}, {1'b0, 10'h283});
    endtask

    task automatic t_bad_ctrl();
        step(8'h00, 1'b1, 1'b1, 1'b0);
        check("R7 bad code", {rd_pos, code_out}, ref_enc(8'h00, 1'b0, 1'b1));
        check("R7 bad flag", {10'd0, ctrl_err}, 11'd1);
        step(8'hBD, 1'b1, 1'b1, 1'b1);
        check("R7 bad code2", {rd_pos, code_out}, ref_enc(8'hBD, 1'b0, 1'b0));
        check("R7 bad flag2", {10'd0, ctrl_err}, 11'd1);
        step(8'hBD, 1'b0, 1'b1, 1'b1);
        check("R7 flag clears", {10'd0, ctrl_err}, 11'd0);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        step(8'h00, 1'b1, 1'b1, 1'b0);
        check("R1 rerun reset", {rd_pos, code_out}, {1'b0, 10'h17C});
        check("R1 rerun err", {10'd0, ctrl_err}, 11'd0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sync();
        t_first_data();
        t_force_continue();
        t_comma_run();
        t_all_data();
        t_kcodes();
        t_bad_ctrl();
        t_reset_again();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule